// File: doc/BRIEF.md
# Ratioed Clock Sync Pulse Generator

This block lives in a fast clock domain and produces the enable that lets data move between that domain and a slower, ratio-locked clock domain. The slow clock is never seen by the block. It is described only by a programmed ratio, given in quarters of a slow period. A ratio of Q quarters means that Q fast cycles span exactly four slow cycles. The pattern of enable positions therefore repeats every Q fast cycles.

An alignment input marks the fast edge where the fast, slow and reference clocks rise together. From that edge the block counts fast cycles modulo Q. In each of the four slow cycles of the period it raises a one-cycle enable on the fast edge closest to the middle of that slow cycle. When two fast edges are equally close, it uses the earlier one. Placing the enable this way keeps setup and hold margins close to equal when the ratio is not a whole number. The same enable qualifies transfers in both directions, so the block drives only one pulse stream.

Top module: `ratio_sync_pulse_gen`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `sync_en` is low. Reset also clears the record of any earlier alignment.
- R2: Until `align` has been sampled high at least once since reset, `sync_en` stays low whatever `ratio_q` holds.
- R3: Call the edge where `align` is sampled high edge 0. For slow slot k (0 to 3), the target edge is e_k = floor(((2k+1)·Q + 3) / 8). This is the integer e that minimises |8e − (2k+1)·Q|, taking the smaller e on a tie. `sync_en` is high during the fast cycle that starts at edge e_k+1 after edge 0, and at the same positions in every later period.
- R4: Within any Q consecutive fast cycles after alignment, `sync_en` is high in exactly four cycles. Each pulse lasts one cycle, and two pulses are never adjacent.
- R5: Without a further `align`, the pattern repeats with a period of exactly Q fast cycles. The internal phase wraps from Q−1 to 0.
- R6: An `align` sampled high while the pattern is running restarts it. The positions after that edge follow R3 as if no earlier alignment had happened.
- R7: `ratio_q` is an unsigned count of quarters and is limited to 8 to 21. A value below 8 acts as 8, and a value above 21 acts as 21.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous active-high reset |
| align | input | 1 | High for the cycle whose closing edge is the coincident edge |
| ratio_q | input | Q_W (5) | Fast-to-slow ratio in quarters |
| sync_en | output | 1 | Registered one-cycle transfer enable |

## Verification
A new `ratio_q` takes one edge to reach the clamped ratio and the slot position table. The bench therefore holds each ratio for four edges before it raises `align`. After the edge that samples `align`, the phase is 0 in cycle 0. The enable for slot k is registered one edge after the phase equals e_k, so it appears in cycle e_k+1. The bench drives and samples 2 ns after each rising edge. It compares `sync_en` in every cycle from 1 to three full periods against a model built from the R3 formula. It also counts pulses per period and rejects adjacent highs.

// File: rtl/spg_pkg.sv
package spg_pkg;

  // Fast edge (counted from the coincident edge) nearest the middle of slow
  // slot k, for a ratio of q / frac fast cycles per slow cycle. A remainder of
  // exactly frac is a tie and rounds down to the earlier edge.
  function automatic int slot_edge(input int q, input int k, input int frac);
    int num;
    num = (2 * k + 1) * q;
    return (num + frac - 1) / (2 * frac);
  endfunction

endpackage

// File: rtl/spg_ratio_table.sv
module spg_ratio_table #(
  parameter int Q_W   = 5,
  parameter int Q_MIN = 8,
  parameter int Q_MAX = 21,
  parameter int SLOTS = 4,
  parameter int FRAC  = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [Q_W-1:0]              ratio_q,
  output logic [Q_W-1:0]              q_eff,
  output logic [SLOTS-1:0][Q_W-1:0]   pos
);

  logic [Q_W-1:0]            q_clamp;
  logic [SLOTS-1:0][Q_W-1:0] pos_n;

  always_comb begin
    if (ratio_q < Q_W'(Q_MIN))
      q_clamp = Q_W'(Q_MIN);
    else if (ratio_q > Q_W'(Q_MAX))
      q_clamp = Q_W'(Q_MAX);
    else
      q_clamp = ratio_q;
  end

  always_comb begin
    for (int k = 0; k < SLOTS; k++)
      pos_n[k] = Q_W'(spg_pkg::slot_edge(int'(q_clamp), k, FRAC));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_eff <= Q_W'(Q_MIN);
      pos   <= '0;
    end else begin
      q_eff <= q_clamp;
      pos   <= pos_n;
    end
  end

endmodule

// File: rtl/spg_phase_ctr.sv
module spg_phase_ctr #(
  parameter int Q_W = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           align,
  input  logic [Q_W-1:0] q_eff,
  output logic [Q_W-1:0] phase,
  output logic           armed
);

  logic last_phase;

  assign last_phase = (phase >= q_eff - Q_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
      armed <= 1'b0;
    end else if (align) begin
      phase <= '0;
      armed <= 1'b1;
    end else if (armed) begin
      phase <= last_phase ? '0 : phase + Q_W'(1);
    end
  end

endmodule

// File: rtl/spg_pulse_match.sv
module spg_pulse_match #(
  parameter int Q_W   = 5,
  parameter int SLOTS = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      armed,
  input  logic [Q_W-1:0]            phase,
  input  logic [SLOTS-1:0][Q_W-1:0] pos,
  output logic                      sync_en
);

  logic [SLOTS-1:0] hit_v;

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    assign hit_v[k] = (phase == pos[k]);
  end

  always_ff @(posedge clk) begin
    if (rst) sync_en <= 1'b0;
    else     sync_en <= armed && (|hit_v);
  end

endmodule

// File: rtl/ratio_sync_pulse_gen.sv
module ratio_sync_pulse_gen #(
  parameter int Q_W   = 5,
  parameter int Q_MIN = 8,
  parameter int Q_MAX = 21,
  parameter int SLOTS = 4,
  parameter int FRAC  = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           align,
  input  logic [Q_W-1:0] ratio_q,
  output logic           sync_en
);

  logic [Q_W-1:0]            q_eff;
  logic [SLOTS-1:0][Q_W-1:0] pos;
  logic [Q_W-1:0]            phase;
  logic                      armed;

  spg_ratio_table #(
    .Q_W(Q_W), .Q_MIN(Q_MIN), .Q_MAX(Q_MAX), .SLOTS(SLOTS), .FRAC(FRAC)
  ) u_table (
    .clk(clk), .rst(rst), .ratio_q(ratio_q), .q_eff(q_eff), .pos(pos)
  );

  spg_phase_ctr #(.Q_W(Q_W)) u_phase (
    .clk(clk), .rst(rst), .align(align), .q_eff(q_eff),
    .phase(phase), .armed(armed)
  );

  spg_pulse_match #(.Q_W(Q_W), .SLOTS(SLOTS)) u_match (
    .clk(clk), .rst(rst), .armed(armed), .phase(phase), .pos(pos),
    .sync_en(sync_en)
  );

endmodule

// File: rtl/spg_checker.sv
module spg_checker #(
  parameter int Q_W = 5
) (
  input logic           clk,
  input logic           rst,
  input logic           align,
  input logic           sync_en,
  input logic [Q_W-1:0] phase,
  input logic [Q_W-1:0] q_eff
);

  logic seen_align;

  always_ff @(posedge clk) begin
    if (rst)        seen_align <= 1'b0;
    else if (align) seen_align <= 1'b1;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !sync_en);

  // R2
  noalign_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !seen_align |-> !sync_en);

  // R4
  pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    sync_en |=> !sync_en);

  // R5
  phase_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (seen_align && !align && phase >= q_eff - Q_W'(1)) |=> (phase == '0));

  // R6
  realign_chk: assert property (@(posedge clk) disable iff (rst)
    align |=> (phase == '0));

endmodule

bind ratio_sync_pulse_gen spg_checker #(.Q_W(Q_W)) u_spg_checker (
  .clk(clk), .rst(rst), .align(align), .sync_en(sync_en),
  .phase(phase), .q_eff(q_eff)
);

// File: tb/ratio_sync_pulse_gen_test.sv
module ratio_sync_pulse_gen_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       align = 1'b0;
  logic [4:0] ratio_q = 5'd11;
  logic       sync_en;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  ratio_sync_pulse_gen uut (
    .clk(clk), .rst(rst), .align(align), .ratio_q(ratio_q), .sync_en(sync_en)
  );

  always #5 clk = ~clk;

  function automatic bit exp_pulse(input int q, input int j);
    int p;
    if (j < 1) return 1'b0;
    p = (j - 1) % q;
    for (int k = 0; k < 4; k++)
      if (p == ((2 * k + 1) * q + 3) / 8) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) tick();
    chk(sync_en == 1'b0, "R1 during reset", sync_en, 0);
    rst = 1'b0;
    tick();
    chk(sync_en == 1'b0, "R1 after reset", sync_en, 0);
  endtask

  task automatic t_quiet(input int q);
    int highs = 0;
    ratio_q = 5'(q);
    for (int i = 0; i < 40; i++) begin
      tick();
      highs += int'(sync_en);
    end
    chk(highs == 0, "R2 no pulses before align", highs, 0);
  endtask

  task automatic do_align();
    align = 1'b1;
    tick();
    align = 1'b0;
  endtask

  task automatic check_run(input int q, input string req);
    int cnt = 0;
    int adj = 0;
    int bad = 0;
    bit prev = 1'b0;
    for (int j = 1; j <= 3 * q; j++) begin
      bit e;
      tick();
      e = exp_pulse(q, j);
      if (sync_en !== e) begin
        bad++;
        chk(1'b0, $sformatf("%s cycle %0d q=%0d", req, j, q), sync_en, e);
      end
      if (sync_en && prev) adj++;
      cnt += int'(sync_en);
      prev = sync_en;
    end
    chk(bad == 0, $sformatf("%s/R5 pattern q=%0d", req, q), bad, 0);
    chk(cnt == 12, $sformatf("R4 pulse count q=%0d", q), cnt, 12);
    chk(adj == 0, $sformatf("R4 single-cycle q=%0d", q), adj, 0);
  endtask

  task automatic t_pattern(input int q_in, input int q_exp, input string req);
    ratio_q = 5'(q_in);
    repeat (4) tick();
    do_align();
    check_run(q_exp, req);
  endtask

  task automatic t_realign(input int q, input int offset);
    ratio_q = 5'(q);
    repeat (4) tick();
    do_align();
    repeat (offset) tick();
    do_align();
    check_run(q, "R6 realign");
  endtask

  task automatic t_reset_mid();
    int highs = 0;
    rst = 1'b1;
    repeat (2) tick();
    rst = 1'b0;
    tick();
    chk(sync_en == 1'b0, "R1 mid-run reset", sync_en, 0);
    for (int i = 0; i < 40; i++) begin
      tick();
      highs += int'(sync_en);
    end
    chk(highs == 0, "R2 disarmed after reset", highs, 0);
  endtask

  initial begin
    t_reset();
    t_quiet(11);
    t_pattern(11, 11, "R3 ratio 2.75");
    t_pattern(8, 8, "R3 ratio 2.00");
    t_pattern(21, 21, "R3 ratio 5.25");
    t_pattern(12, 12, "R3 tie ratio 3.00");
    t_pattern(10, 10, "R3 ratio 2.50");
    t_pattern(3, 8, "R7 clamp low");
    t_pattern(30, 21, "R7 clamp high");
    t_realign(11, 5);
    t_realign(13, 17);
    t_reset_mid();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  end

endmodule